// File: doc/BRIEF.md
# Context-Aware Prefetch Issue Unit

This unit runs beside a processor and a reconfiguration controller. It decides, at run time, which hardware module configuration should be fetched next. It keeps a small call-context stack in hardware. A call event pushes the call-site identifier onto the stack, and a return event pops it. When the program reaches a node that carries a prefetch table, the table is shown to the unit as a set of labelled priority queues. The unit picks the first queue whose label matches the two most recent call sites. It then applies a three-way issue rule. The rule looks at whether the queue head is resident, whether the controller is busy, and the queue position of the module now being loaded.

The unit also decides how a hardware candidate runs once execution reaches it. A resident module runs in hardware. A module that is not resident is loaded and then run in hardware, but only when the remaining load time plus its hardware time is shorter than its software time. In every other case the software version runs. All decisions are registered and appear one clock after the event that caused them.

Top module: `ctx_prefetch_unit`

## Requirements
- R1: A call event pushes `call_site` onto the context stack and a return event pops the top entry, so matching always sees the most recent unreturned call site as position 0 and the one before it as position 1.
- R2: A label is selected only when it is enabled and both of its site positions match. Site 0 is compared with stack position 0 and site 1 with stack position 1. A position the stack does not hold never matches a real site. When several labels match, the one with the lowest index selects the queue.
- R3: A set don't-care bit for a label position makes that position match anything, including a stack too shallow to hold it.
- R4: If the selected queue's head is not resident and the controller is idle, a load of the head is requested. If the controller is busy loading the head itself, nothing is requested.
- R5: If the head is resident, the first later queue entry that is not resident is a candidate. The candidate gets a load request only when the controller is idle. If every entry is resident, nothing is requested.
- R6: While the controller is busy, a preempt request names a module only if that module sits at a strictly smaller queue index than the module being loaded. A module that is not in the queue ranks below index 3.
- R7: The stack holds 16 entries. A push onto a full stack discards the oldest entry and keeps the 16 newest.
- R8: A return on an empty stack pulses `ctx_err` for one cycle and leaves the stack empty.
- R9: A node event with no matching label, or with an empty selected queue, produces neither a load nor a preempt request.
- R10: `load_req` and `preempt_req` rise in the cycle after the node event and last one cycle. At most one of them is high at a time, and `req_mod` carries the module for either one.
- R11: A reached candidate whose residency bit is set gets `exec_mode` 0, which means run in hardware. `exec_vld` is high in the cycle after `hit_vld`.
- R12: A reached candidate that is not resident gets `exec_mode` 1 (load, then run in hardware) when `hit_left + hit_hw < hit_sw`. Otherwise it gets `exec_mode` 2 (run in software).
- R13: A node event is matched against the stack as it stood before any call or return in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_vld | input | 1 | Call-site event, pushes `call_site` |
| call_site | input | 4 | Call-site identifier |
| ret_vld | input | 1 | Return event, pops the stack |
| node_vld | input | 1 | Node with a prefetch table reached |
| lbl_en | input | 2 | Per-label enable |
| lbl_dc | input | 4 | Don't-care bits; label l position k at bit 2l+k |
| lbl_site | input | 16 | Label sites; label l position k at bits (2l+k)*4 +: 4 |
| q_len | input | 6 | Queue lengths 0..4; queue l at bits 3l +: 3 |
| q_ids | input | 32 | Queue module IDs; queue l index i at bits (4l+i)*4 +: 4, index 0 highest |
| res_mask | input | 16 | Residency bit per module ID |
| ctl_busy | input | 1 | Controller is loading a module |
| ctl_mod | input | 4 | Module being loaded |
| hit_vld | input | 1 | Hardware candidate reached |
| hit_mod | input | 4 | Reached module ID |
| hit_left | input | 12 | Remaining load time for the reached module |
| hit_hw | input | 12 | Hardware run time |
| hit_sw | input | 12 | Software run time |
| load_req | output | 1 | Start-load request |
| preempt_req | output | 1 | Preempt current load in favour of `req_mod` |
| req_mod | output | 4 | Module for the request |
| exec_vld | output | 1 | Execution decision valid |
| exec_mode | output | 2 | 0 hardware, 1 load then hardware, 2 software |
| ctx_err | output | 1 | Pop on empty stack |

## Verification
The case that needs care is a node event in the same cycle as a call, because matching and the stack update both read and change the same context. The bench raises `node_vld` together with `call_vld` for a site that a label wants in position 0. No request is expected in that cycle's result. A second node event one cycle later must then issue the load, which shows that matching used the stack before the push. Return events that arrive alongside the error case are judged by the `ctx_err` pulse and by later label matches that show the stack depth.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
   typedef enum logic [1:0] {
      EXEC_HW      = 2'd0,
      EXEC_LOAD_HW = 2'd1,
      EXEC_SW      = 2'd2
   } exec_mode_e;
endpackage

// File: rtl/ctx_stack.sv
module ctx_stack #(
   parameter int SITE_W = 4,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [SITE_W-1:0] push_site,
   output logic [SITE_W-1:0] top0,
   output logic [SITE_W-1:0] top1,
   output logic              has0,
   output logic              has1,
   output logic              underflow
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ctx_stack needs DEPTH >= 2");
      end
   endgenerate

   logic [SITE_W-1:0] stk [DEPTH];
   logic [CW-1:0]     cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         underflow <= 1'b0;
         for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
      end else begin
         underflow <= 1'b0;
         if (push && !pop) begin
            stk[0] <= push_site;
            for (int i = 1; i < DEPTH; i++) stk[i] <= stk[i-1];
            if (cnt != CW'(DEPTH)) cnt <= cnt + 1'b1;
         end else if (pop && !push) begin
            if (cnt == '0) begin
               underflow <= 1'b1;
            end else begin
               for (int i = 0; i < DEPTH-1; i++) stk[i] <= stk[i+1];
               stk[DEPTH-1] <= '0;
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   assign top0 = stk[0];
   assign top1 = stk[1];
   assign has0 = (cnt != '0);
   assign has1 = (cnt > CW'(1));

   // R1
   push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (top0 == $past(push_site)));
   // R8
   underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && cnt == '0) |=> (underflow && cnt == '0));
   // R7
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && cnt == CW'(DEPTH)) |=> (cnt == CW'(DEPTH) && stk[DEPTH-1] == $past(stk[DEPTH-2])));
endmodule

// File: rtl/ctx_label_match.sv
module ctx_label_match #(
   parameter int SITE_W = 4,
   parameter int NLBL   = 2,
   localparam int LW    = (NLBL > 1) ? $clog2(NLBL) : 1
) (
   input  logic [SITE_W-1:0]        top0,
   input  logic [SITE_W-1:0]        top1,
   input  logic                     has0,
   input  logic                     has1,
   input  logic [NLBL-1:0]          lbl_en,
   input  logic [2*NLBL-1:0]        lbl_dc,
   input  logic [2*NLBL*SITE_W-1:0] lbl_site,
   output logic                     hit,
   output logic [LW-1:0]            sel
);
   logic m0, m1;

   always_comb begin
      hit = 1'b0;
      sel = '0;
      m0  = 1'b0;
      m1  = 1'b0;
      for (int l = NLBL-1; l >= 0; l--) begin
         m0 = lbl_dc[2*l]   || (has0 && lbl_site[(2*l)*SITE_W +: SITE_W] == top0);
         m1 = lbl_dc[2*l+1] || (has1 && lbl_site[(2*l+1)*SITE_W +: SITE_W] == top1);
         if (lbl_en[l] && m0 && m1) begin
            hit = 1'b1;
            sel = LW'(l);
         end
      end
   end
endmodule

// File: rtl/prefetch_issue_rule.sv
module prefetch_issue_rule #(
   parameter int MOD_W = 4,
   parameter int QLEN  = 4,
   localparam int NMOD = 1 << MOD_W,
   localparam int PW   = $clog2(QLEN + 1)
) (
   input  logic [QLEN*MOD_W-1:0] q_ids,
   input  logic [PW-1:0]         q_len,
   input  logic [NMOD-1:0]       res_mask,
   input  logic                  busy,
   input  logic [MOD_W-1:0]      ctl_mod,
   output logic                  want_load,
   output logic                  want_pre,
   output logic [MOD_W-1:0]      want_mod
);
   generate
      if (QLEN < 2) begin : g_bad_qlen
         $error("prefetch_issue_rule needs QLEN >= 2");
      end
   endgenerate

   logic [MOD_W-1:0] ids [QLEN];
   genvar gi;
   generate
      for (gi = 0; gi < QLEN; gi++) begin : g_ids
         assign ids[gi] = q_ids[gi*MOD_W +: MOD_W];
      end
   endgenerate

   logic [PW-1:0]    ppos, cpos;
   logic [MOD_W-1:0] cmod;

   always_comb begin
      ppos = PW'(QLEN);
      for (int i = QLEN-1; i >= 0; i--)
         if (PW'(i) < q_len && ids[i] == ctl_mod) ppos = PW'(i);
      cpos = PW'(QLEN);
      cmod = ids[0];
      for (int i = QLEN-1; i >= 1; i--)
         if (PW'(i) < q_len && !res_mask[ids[i]]) begin
            cpos = PW'(i);
            cmod = ids[i];
         end
      want_load = 1'b0;
      want_pre  = 1'b0;
      want_mod  = ids[0];
      if (q_len != '0) begin
         if (!res_mask[ids[0]]) begin
            if (!busy)            want_load = 1'b1;
            else if (ppos != '0)  want_pre  = 1'b1;
         end else if (cpos != PW'(QLEN)) begin
            want_mod = cmod;
            if (!busy)            want_load = 1'b1;
            else if (cpos < ppos) want_pre  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/exec_select.sv
module exec_select
   import pfu_pkg::*;
#(
   parameter int TIME_W = 12
) (
   input  logic              resident,
   input  logic [TIME_W-1:0] left_t,
   input  logic [TIME_W-1:0] hw_t,
   input  logic [TIME_W-1:0] sw_t,
   output exec_mode_e        mode
);
   logic [TIME_W:0] via_hw;

   always_comb begin
      via_hw = {1'b0, left_t} + {1'b0, hw_t};
      if (resident)                  mode = EXEC_HW;
      else if (via_hw < {1'b0, sw_t}) mode = EXEC_LOAD_HW;
      else                           mode = EXEC_SW;
   end
endmodule

// File: rtl/ctx_prefetch_unit.sv
module ctx_prefetch_unit
   import pfu_pkg::*;
#(
   parameter int SITE_W = 4,
   parameter int MOD_W  = 4,
   parameter int DEPTH  = 16,
   parameter int QLEN   = 4,
   parameter int NLBL   = 2,
   parameter int TIME_W = 12,
   localparam int NMOD  = 1 << MOD_W,
   localparam int PW    = $clog2(QLEN + 1),
   localparam int LW    = (NLBL > 1) ? $clog2(NLBL) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     call_vld,
   input  logic [SITE_W-1:0]        call_site,
   input  logic                     ret_vld,
   input  logic                     node_vld,
   input  logic [NLBL-1:0]          lbl_en,
   input  logic [2*NLBL-1:0]        lbl_dc,
   input  logic [2*NLBL*SITE_W-1:0] lbl_site,
   input  logic [NLBL*PW-1:0]       q_len,
   input  logic [NLBL*QLEN*MOD_W-1:0] q_ids,
   input  logic [NMOD-1:0]          res_mask,
   input  logic                     ctl_busy,
   input  logic [MOD_W-1:0]         ctl_mod,
   input  logic                     hit_vld,
   input  logic [MOD_W-1:0]         hit_mod,
   input  logic [TIME_W-1:0]        hit_left,
   input  logic [TIME_W-1:0]        hit_hw,
   input  logic [TIME_W-1:0]        hit_sw,
   output logic                     load_req,
   output logic                     preempt_req,
   output logic [MOD_W-1:0]         req_mod,
   output logic                     exec_vld,
   output logic [1:0]               exec_mode,
   output logic                     ctx_err
);
   generate
      if (NLBL < 1) begin : g_bad_nlbl
         $error("ctx_prefetch_unit needs NLBL >= 1");
      end
   endgenerate

   logic [SITE_W-1:0] top0, top1;
   logic              has0, has1;

   ctx_stack #(.SITE_W(SITE_W), .DEPTH(DEPTH)) stack_i (
      .clk(clk), .rst_n(rst_n), .push(call_vld), .pop(ret_vld),
      .push_site(call_site), .top0(top0), .top1(top1),
      .has0(has0), .has1(has1), .underflow(ctx_err)
   );

   logic          lbl_hit;
   logic [LW-1:0] lbl_sel;

   ctx_label_match #(.SITE_W(SITE_W), .NLBL(NLBL)) match_i (
      .top0(top0), .top1(top1), .has0(has0), .has1(has1),
      .lbl_en(lbl_en), .lbl_dc(lbl_dc), .lbl_site(lbl_site),
      .hit(lbl_hit), .sel(lbl_sel)
   );

   logic [QLEN*MOD_W-1:0] sel_ids;
   logic [PW-1:0]         sel_len;

   assign sel_ids = q_ids[lbl_sel*(QLEN*MOD_W) +: QLEN*MOD_W];
   assign sel_len = q_len[lbl_sel*PW +: PW];

   logic             want_load, want_pre;
   logic [MOD_W-1:0] want_mod;

   prefetch_issue_rule #(.MOD_W(MOD_W), .QLEN(QLEN)) rule_i (
      .q_ids(sel_ids), .q_len(sel_len), .res_mask(res_mask),
      .busy(ctl_busy), .ctl_mod(ctl_mod),
      .want_load(want_load), .want_pre(want_pre), .want_mod(want_mod)
   );

   exec_mode_e mode_nx;

   exec_select #(.TIME_W(TIME_W)) exec_i (
      .resident(res_mask[hit_mod]), .left_t(hit_left),
      .hw_t(hit_hw), .sw_t(hit_sw), .mode(mode_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_req    <= 1'b0;
         preempt_req <= 1'b0;
         req_mod     <= '0;
         exec_vld    <= 1'b0;
         exec_mode   <= 2'd0;
      end else begin
         load_req    <= node_vld && lbl_hit && want_load;
         preempt_req <= node_vld && lbl_hit && want_pre;
         if (node_vld) req_mod <= want_mod;
         exec_vld    <= hit_vld;
         if (hit_vld) exec_mode <= mode_nx;
      end
   end

   // R10
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load_req, preempt_req}));
   // R5
   load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_req |-> $past(!ctl_busy));
   // R6
   pre_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      preempt_req |-> $past(ctl_busy));
   // R9
   no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (node_vld && !lbl_hit) |=> (!load_req && !preempt_req));
   // R11
   hw_resident_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_vld && exec_mode == 2'd0) |-> $past(res_mask[hit_mod]));
endmodule

// File: tb/ctx_prefetch_unit_tb_top.sv
module ctx_prefetch_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        call_vld = 1'b0, ret_vld = 1'b0, node_vld = 1'b0, hit_vld = 1'b0;
   logic [3:0]  call_site = '0;
   logic [1:0]  lbl_en = '0;
   logic [3:0]  lbl_dc = '0;
   logic [15:0] lbl_site = '0;
   logic [5:0]  q_len = '0;
   logic [31:0] q_ids = '0;
   logic [15:0] res_mask = '0;
   logic        ctl_busy = 1'b0;
   logic [3:0]  ctl_mod = '0, hit_mod = '0;
   logic [11:0] hit_left = '0, hit_hw = '0, hit_sw = '0;
   logic        load_req, preempt_req, exec_vld, ctx_err;
   logic [3:0]  req_mod;
   logic [1:0]  exec_mode;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   ctx_prefetch_unit dut_i (
      .clk(clk), .rst_n(rst_n), .call_vld(call_vld), .call_site(call_site),
      .ret_vld(ret_vld), .node_vld(node_vld), .lbl_en(lbl_en), .lbl_dc(lbl_dc),
      .lbl_site(lbl_site), .q_len(q_len), .q_ids(q_ids), .res_mask(res_mask),
      .ctl_busy(ctl_busy), .ctl_mod(ctl_mod), .hit_vld(hit_vld), .hit_mod(hit_mod),
      .hit_left(hit_left), .hit_hw(hit_hw), .hit_sw(hit_sw), .load_req(load_req),
      .preempt_req(preempt_req), .req_mod(req_mod), .exec_vld(exec_vld),
      .exec_mode(exec_mode), .ctx_err(ctx_err)
   );

   // {resident, left, hw, sw, expected mode}
   localparam logic [38:0] HIT_VEC [5] = '{
      {1'b1, 12'd500, 12'd5,  12'd20, 2'd0},
      {1'b0, 12'd10,  12'd5,  12'd20, 2'd1},
      {1'b0, 12'd15,  12'd5,  12'd20, 2'd2},
      {1'b0, 12'd14,  12'd5,  12'd20, 2'd1},
      {1'b0, 12'd0,   12'd30, 12'd20, 2'd2}
   };

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic set_lbl(int l, logic en, logic [3:0] s0, logic d0, logic [3:0] s1, logic d1);
      lbl_en[l] = en;
      lbl_dc[2*l] = d0;
      lbl_dc[2*l+1] = d1;
      lbl_site[(2*l)*4 +: 4] = s0;
      lbl_site[(2*l+1)*4 +: 4] = s1;
   endtask

   task automatic set_q(int l, logic [2:0] n, logic [3:0] a, logic [3:0] b, logic [3:0] c, logic [3:0] d);
      q_len[l*3 +: 3] = n;
      q_ids[l*16 +: 16] = {d, c, b, a};
   endtask

   task automatic node(string tag, logic ld, logic pr, logic [3:0] m);
      node_vld = 1'b1;
      tick();
      node_vld = 1'b0;
      chk({tag, " load"}, {7'd0, load_req}, {7'd0, ld});
      chk({tag, " preempt"}, {7'd0, preempt_req}, {7'd0, pr});
      if (ld || pr) chk({tag, " module"}, {4'd0, req_mod}, {4'd0, m});
   endtask

   task automatic push(logic [3:0] s);
      call_vld = 1'b1;
      call_site = s;
      tick();
      call_vld = 1'b0;
   endtask

   task automatic pop(string tag, logic exp_err);
      ret_vld = 1'b1;
      tick();
      ret_vld = 1'b0;
      chk(tag, {7'd0, ctx_err}, {7'd0, exp_err});
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("reset R10 load", {7'd0, load_req}, 8'd0);
      chk("reset R10 preempt", {7'd0, preempt_req}, 8'd0);
      chk("reset R11 exec_vld", {7'd0, exec_vld}, 8'd0);
      chk("reset R8 err", {7'd0, ctx_err}, 8'd0);

      // hit decision vectors: R11, R12
      hit_mod = 4'd3;
      for (int v = 0; v < 5; v++) begin
         res_mask = '0;
         res_mask[3] = HIT_VEC[v][38];
         hit_left = HIT_VEC[v][37:26];
         hit_hw = HIT_VEC[v][25:14];
         hit_sw = HIT_VEC[v][13:2];
         hit_vld = 1'b1;
         tick();
         hit_vld = 1'b0;
         chk("R11 R12 exec_vld", {7'd0, exec_vld}, 8'd1);
         chk("R11 R12 exec_mode", {6'd0, exec_mode}, {6'd0, HIT_VEC[v][1:0]});
      end
      res_mask = '0;
      tick();
      chk("R11 exec_vld pulse", {7'd0, exec_vld}, 8'd0);

      // empty stack, all don't-care label: R3, R4
      set_lbl(0, 1'b1, 4'd0, 1'b1, 4'd0, 1'b1);
      set_q(0, 3'd2, 4'd3, 4'd5, 4'd0, 4'd0);
      set_lbl(1, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0);
      node("R3 R4 dc on empty", 1'b1, 1'b0, 4'd3);
      tick();
      chk("R10 request pulse", {7'd0, load_req}, 8'd0);

      push(4'd2);
      push(4'd7);   // stack: 7, 2

      set_lbl(0, 1'b1, 4'd9, 1'b0, 4'd2, 1'b0);
      set_q(0, 3'd1, 4'd1, 4'd0, 4'd0, 4'd0);
      set_lbl(1, 1'b1, 4'd7, 1'b0, 4'd2, 1'b0);
      set_q(1, 3'd3, 4'd4, 4'd6, 4'd8, 4'd0);
      node("R1 R2 two-site match", 1'b1, 1'b0, 4'd4);

      set_lbl(0, 1'b1, 4'd7, 1'b0, 4'd15, 1'b1);
      set_q(0, 3'd1, 4'd10, 4'd0, 4'd0, 4'd0);
      node("R2 R3 lowest label wins", 1'b1, 1'b0, 4'd10);

      set_lbl(0, 1'b1, 4'd8, 1'b0, 4'd0, 1'b1);
      set_lbl(1, 1'b1, 4'd7, 1'b0, 4'd3, 1'b0);
      node("R9 no label match", 1'b0, 1'b0, 4'd0);

      set_lbl(0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0);
      set_lbl(1, 1'b1, 4'd7, 1'b0, 4'd2, 1'b0);
      res_mask = 16'h0050;   // 4 and 6 resident
      node("R5 next non-resident idle", 1'b1, 1'b0, 4'd8);
      ctl_busy = 1'b1;
      ctl_mod = 4'd8;
      node("R5 R6 busy on candidate", 1'b0, 1'b0, 4'd0);
      ctl_mod = 4'd11;
      node("R6 preempt absent module", 1'b0, 1'b1, 4'd8);
      res_mask = '0;
      ctl_mod = 4'd4;
      node("R4 head already loading", 1'b0, 1'b0, 4'd0);
      ctl_mod = 4'd6;
      node("R6 preempt for head", 1'b0, 1'b1, 4'd4);
      ctl_busy = 1'b0;
      res_mask = 16'h0150;
      node("R5 all resident", 1'b0, 1'b0, 4'd0);
      res_mask = '0;
      set_q(1, 3'd0, 4'd4, 4'd6, 4'd8, 4'd0);
      node("R9 empty queue", 1'b0, 1'b0, 4'd0);

      // same-cycle node and call: R13
      set_lbl(1, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0);
      set_lbl(0, 1'b1, 4'd9, 1'b0, 4'd0, 1'b1);
      set_q(0, 3'd1, 4'd12, 4'd0, 4'd0, 4'd0);
      call_vld = 1'b1;
      call_site = 4'd9;
      node("R13 match before push", 1'b0, 1'b0, 4'd0);
      call_vld = 1'b0;
      node("R13 match after push", 1'b1, 1'b0, 4'd12);

      pop("R1 pop 9", 1'b0);
      pop("R1 pop 7", 1'b0);
      pop("R1 pop 2", 1'b0);
      pop("R8 pop empty", 1'b1);
      tick();
      chk("R8 err pulse", {7'd0, ctx_err}, 8'd0);
      set_lbl(0, 1'b1, 4'd0, 1'b1, 4'd0, 1'b1);
      set_q(0, 3'd1, 4'd13, 4'd0, 4'd0, 4'd0);
      node("R8 stack stays usable", 1'b1, 1'b0, 4'd13);

      // overflow: R7
      for (int i = 1; i <= 17; i++) push(4'(i));
      for (int i = 0; i < 15; i++) pop("R7 pop retained", 1'b0);
      set_lbl(0, 1'b1, 4'd2, 1'b0, 4'd0, 1'b0);
      node("R7 depth one left", 1'b0, 1'b0, 4'd0);
      set_lbl(0, 1'b1, 4'd2, 1'b0, 4'd0, 1'b1);
      node("R7 oldest kept is site 2", 1'b1, 1'b0, 4'd13);
      pop("R7 last retained", 1'b0);
      pop("R7 R8 dropped entry gone", 1'b1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule